// File: doc/BRIEF.md
# Dual-Rail Configurable Two-Input Logic Unit

This block computes one of the sixteen Boolean functions of two variables on dual-rail tokens. Each of its two operands and its result uses two wires. Both wires low is the empty spacer. The true rail alone high means logic 1, and the false rail alone high means logic 0. Both wires high is illegal. The block is modelled as a synchronous four-phase stage. It stays empty until both operands carry data. It then produces one result token and holds it until both operands return to the spacer.

The function is set by eight switch bits, arranged as four complementary pairs, one pair for each truth-table row. The switches are written before data arrives. An illegal switch setting or an illegal operand code is reported on a flag and never produces a result token.

Top module: `dr_logic_unit`

## Requirements
- R1: After reset the result is 00 and `tok_err` is 0.
- R2: Dual-rail codes on `a_dr`, `b_dr` and `z_dr` are 00 = empty, 01 = logic 0 (false rail, bit 0), 10 = logic 1 (true rail, bit 1), 11 = illegal. The result never shows 11.
- R3: While fewer than two operands hold a valid code, the result stays 00.
- R4: When both operands are valid, the configuration is legal and the unit is idle, the result shows the selected truth-table entry one clock later. The row index is {A,B}. Row r uses switch pair `cfg_sw[2r+1:2r]`: 10 selects 1 and 01 selects 0. For example, AND is 8'b10_01_01_01.
- R5: A result is held while either operand is still non-empty. It returns to 00 one clock after both operands are 00.
- R6: `cfg_err` is high in the same cycle in which any switch pair is 00 or 11. While it is high, no result token is produced.
- R7: An operand code of 11 forces the result to 00 on the next clock and sets `tok_err`, which stays set until reset. No new token is evaluated until both operands have been 00.
- R8: A change of `cfg_sw` while a result is held leaves that result unchanged. The next token uses the new setting.
- R9: Each of the 16 switch settings yields its own function over all four operand rows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sw | input | 8 | Four complementary truth-table switch pairs |
| a_dr | input | 2 | Dual-rail operand A |
| b_dr | input | 2 | Dual-rail operand B |
| z_dr | output | 2 | Dual-rail result |
| cfg_err | output | 1 | Illegal switch pair present |
| tok_err | output | 1 | Sticky illegal operand code seen |

## Verification
Two events can fall in the same cycle: an illegal code on one operand, and the completion of the pair by the other operand. The bench drives A = 11 together with a valid B, and separately an illegal code while a result is held. It expects the error path to win: the result is 00 on the next clock, the flag is set, and a following valid pair is ignored until both operands are empty. A second overlap is a switch change in the cycle a result is held, and that change must only show on the next token.

// File: rtl/dr_logic_unit.sv
module dr_logic_unit #(
  parameter int ROWS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2*ROWS-1:0] cfg_sw,
  input  logic [1:0]       a_dr,
  input  logic [1:0]       b_dr,
  output logic [1:0]       z_dr,
  output logic             cfg_err,
  output logic             tok_err
);
  localparam int IW = $clog2(2*ROWS);

  typedef enum logic [1:0] {S_EMPTY, S_FULL, S_DRAIN} st_t;
  st_t st;

  logic [ROWS-1:0] pair_ok;
  for (genvar r = 0; r < ROWS; r++) begin : g_pair
    assign pair_ok[r] = cfg_sw[2*r+1] ^ cfg_sw[2*r];
  end
  assign cfg_err = ~&pair_ok;

  wire a_ok  = a_dr[1] ^ a_dr[0];
  wire b_ok  = b_dr[1] ^ b_dr[0];
  wire bad   = (&a_dr) | (&b_dr);
  wire empty = ~|{a_dr, b_dr};

  wire [IW-1:0] sel = IW'({a_dr[1], b_dr[1], 1'b1});
  wire          res = cfg_sw[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_EMPTY;
      z_dr    <= 2'b00;
      tok_err <= 1'b0;
    end else if (bad) begin
      st      <= S_DRAIN;
      z_dr    <= 2'b00;
      tok_err <= 1'b1;
    end else begin
      case (st)
        S_EMPTY: if (a_ok && b_ok && !cfg_err) begin
          z_dr <= res ? 2'b10 : 2'b01;
          st   <= S_FULL;
        end
        S_FULL: if (empty) begin
          z_dr <= 2'b00;
          st   <= S_EMPTY;
        end
        default: if (empty) st <= S_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/dr_logic_unit_chk.sv
module dr_logic_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] a_dr,
  input logic [1:0] b_dr,
  input logic [1:0] z_dr,
  input logic       cfg_err,
  input logic       tok_err
);
  wire a_ok  = (a_dr == 2'b01) || (a_dr == 2'b10);
  wire b_ok  = (b_dr == 2'b01) || (b_dr == 2'b10);
  wire bad   = (a_dr == 2'b11) || (b_dr == 2'b11);
  wire empty = (a_dr == 2'b00) && (b_dr == 2'b00);

  always_comb begin
    if (rst_n) p_no_illegal_out_r2: assert (z_dr != 2'b11);
  end

  p_null_until_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (z_dr == 2'b00 && !(a_ok && b_ok)) |=> z_dr == 2'b00);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (z_dr != 2'b00 && !empty && !bad) |=> $stable(z_dr));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (z_dr != 2'b00 && empty) |=> z_dr == 2'b00);

  p_cfg_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (z_dr == 2'b00 && cfg_err) |=> z_dr == 2'b00);

  p_bad_token_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (z_dr == 2'b00 && tok_err));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tok_err |=> tok_err);
endmodule

bind dr_logic_unit dr_logic_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .a_dr(a_dr), .b_dr(b_dr),
  .z_dr(z_dr), .cfg_err(cfg_err), .tok_err(tok_err)
);

// File: tb/dr_logic_unit_test.sv
module dr_logic_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_sw = 8'b10_01_01_01;
  logic [1:0] a_dr = 2'b00, b_dr = 2'b00;
  logic [1:0] z_dr;
  logic       cfg_err, tok_err;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  dr_logic_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_sw(cfg_sw), .a_dr(a_dr), .b_dr(b_dr),
    .z_dr(z_dr), .cfg_err(cfg_err), .tok_err(tok_err)
  );

  localparam logic [7:0] F_AND  = 8'b10_01_01_01;
  localparam logic [7:0] F_OR   = 8'b10_10_10_01;
  localparam logic [7:0] F_XOR  = 8'b01_10_10_01;
  localparam logic [7:0] F_NAND = 8'b01_10_10_10;
  localparam logic [7:0] F_ONE  = 8'b10_10_10_10;
  localparam logic [7:0] F_ZERO = 8'b01_01_01_01;

  // {cfg, a, b, expected z}
  localparam int NV = 10;
  localparam logic [13:0] VEC [NV] = '{
    {F_AND,  2'b10, 2'b10, 2'b10},
    {F_AND,  2'b10, 2'b01, 2'b01},
    {F_OR,   2'b01, 2'b01, 2'b01},
    {F_OR,   2'b01, 2'b10, 2'b10},
    {F_XOR,  2'b10, 2'b10, 2'b01},
    {F_XOR,  2'b10, 2'b01, 2'b10},
    {F_NAND, 2'b10, 2'b10, 2'b01},
    {F_NAND, 2'b01, 2'b01, 2'b10},
    {F_ONE,  2'b01, 2'b01, 2'b10},
    {F_ZERO, 2'b10, 2'b10, 2'b01}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] a, logic [1:0] b);
    a_dr = a; b_dr = b;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] cfg_of(logic [3:0] f);
    logic [7:0] c;
    for (int r = 0; r < 4; r++) c[2*r +: 2] = f[r] ? 2'b10 : 2'b01;
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset z", {6'd0, z_dr}, 8'd0);
    chk("R1 reset tok_err", {7'd0, tok_err}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      cfg_sw = VEC[i][13:6];
      step(VEC[i][5:4], VEC[i][3:2]);
      chk($sformatf("R4 R2 vector %0d", i), {6'd0, z_dr}, {6'd0, VEC[i][1:0]});
      step(2'b00, 2'b00);
      chk($sformatf("R5 release %0d", i), {6'd0, z_dr}, 8'd0);
    end

    for (int f = 0; f < 16; f++) begin
      cfg_sw = cfg_of(4'(f));
      for (int r = 0; r < 4; r++) begin
        step(r[1] ? 2'b10 : 2'b01, r[0] ? 2'b10 : 2'b01);
        chk($sformatf("R9 func %0d row %0d", f, r), {6'd0, z_dr},
            {6'd0, (f[r] ? 2'b10 : 2'b01)});
        step(2'b00, 2'b00);
      end
    end

    // R3: a single valid operand never fires
    cfg_sw = F_OR;
    step(2'b10, 2'b00);
    step(2'b10, 2'b00);
    chk("R3 only A valid", {6'd0, z_dr}, 8'd0);
    step(2'b00, 2'b01);
    chk("R3 only B valid", {6'd0, z_dr}, 8'd0);
    step(2'b10, 2'b01);
    chk("R4 pair completes", {6'd0, z_dr}, 8'b10);

    // R5: partial release holds
    step(2'b00, 2'b01);
    step(2'b00, 2'b01);
    chk("R5 hold on partial release", {6'd0, z_dr}, 8'b10);
    step(2'b00, 2'b00);
    chk("R5 release after both empty", {6'd0, z_dr}, 8'd0);

    // R8: config change while holding
    cfg_sw = F_AND;
    step(2'b10, 2'b10);
    chk("R8 AND result", {6'd0, z_dr}, 8'b10);
    cfg_sw = F_NAND;
    step(2'b10, 2'b10);
    chk("R8 held despite new cfg", {6'd0, z_dr}, 8'b10);
    step(2'b00, 2'b00);
    step(2'b10, 2'b10);
    chk("R8 next token uses NAND", {6'd0, z_dr}, 8'b01);
    step(2'b00, 2'b00);

    // R6: illegal switch pairs
    cfg_sw = 8'b11_01_01_01;
    #1 chk("R6 cfg_err pair 11", {7'd0, cfg_err}, 8'd1);
    step(2'b10, 2'b10);
    step(2'b10, 2'b10);
    chk("R6 no token with bad cfg", {6'd0, z_dr}, 8'd0);
    cfg_sw = 8'b01_01_00_01;
    #1 chk("R6 cfg_err pair 00", {7'd0, cfg_err}, 8'd1);
    step(2'b00, 2'b00);
    cfg_sw = F_AND;
    #1 chk("R6 cfg_err clear", {7'd0, cfg_err}, 8'd0);

    // R7: illegal code in the cycle the pair completes
    step(2'b11, 2'b10);
    chk("R7 z empty on illegal code", {6'd0, z_dr}, 8'd0);
    chk("R7 tok_err set", {7'd0, tok_err}, 8'd1);
    step(2'b10, 2'b10);
    chk("R7 waits for empty", {6'd0, z_dr}, 8'd0);
    step(2'b00, 2'b00);
    step(2'b10, 2'b10);
    chk("R7 resumes after empty", {6'd0, z_dr}, 8'b10);
    chk("R7 tok_err sticky", {7'd0, tok_err}, 8'd1);
    // illegal code while result held
    step(2'b10, 2'b11);
    chk("R7 held result dropped", {6'd0, z_dr}, 8'd0);
    step(2'b00, 2'b00);

    rst_n = 1'b0;
    step(2'b00, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset clears tok_err", {7'd0, tok_err}, 8'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule